// File: doc/BRIEF.md
# Sleep Wake Change Monitor

This block watches a vector of general-purpose input pins while the chip is in deep sleep. It raises a wake request when an enabled pin moves away from the level it held when sleep began. On the sleep-entry strobe it latches every pin's digital level into a snapshot and arms itself. From then on it compares each pin against its snapshot, either directly or through a three-sample digital filter clocked by a slow sample tick.

Three things gate a wake:

- a per-pin wake-enable mask,
- a global pin-wake select bit,
- an analog-mode mask. A pin in analog mode reads as logic 1, so it can never change.

The result is one sticky status flag that says pin activity caused the wake. It does not say which pin did. Software finds the pin by reading the pins afterwards. The flag and the wake request hold until software pulses the clear input or a new sleep entry occurs. The clear input also disarms the monitor until the next sleep entry.

Pin inputs are asynchronous and pass through a two-flop synchronizer. The sample tick is a single-cycle enable pulse in the main clock domain.

Top module: `wake_change_monitor`

## Requirements
- R1: On the cycle `sleep_enter_i` is high, the synchronized digital level of every pin is latched as the snapshot and the monitor is armed. A pin that keeps its snapshot level never causes a wake.
- R2: Detection is by difference from the snapshot, not by edge type. A 0-to-1 change and a 1-to-0 change on an enabled pin both wake.
- R3: A pin whose bit in `wake_en_i` is 0 never causes a wake, whatever its activity.
- R4: While `gpio_wake_sel_i` is 0, no pin change sets the status.
- R5: A pin whose bit in `analog_i` is 1 is read as logic 1 for both snapshot and comparison, so toggling it never causes a wake.
- R6: With `filt_en_i` = 0, a difference on an enabled pin sets `wake_req_o` and `gpio_wake_sts_o`. They are high after the third rising clock edge following the pin change and low after the second (two synchronizer flops plus the status flop).
- R7: With `filt_en_i` = 1, a pin is sampled only on `sample_tick_i` pulses. A wake needs three consecutive samples since the last sleep entry that all agree and differ from the snapshot. Two samples are not enough.
- R8: With filtering on, a deviation seen in fewer than three consecutive samples, followed by a return to the snapshot level, produces no wake.
- R9: Once set, status and wake request stay high after the pin returns to its snapshot level. A `clear_i` pulse clears them. A sleep entry clears them and discards the filter sample history.
- R10: After reset both outputs are 0 and the monitor is not armed. Pin changes before the first sleep entry cause no wake.
- R11: After `clear_i` the monitor is disarmed. Pin changes cause no wake until the next sleep entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | N_PINS | Raw asynchronous pin levels |
| sleep_enter_i | input | 1 | Single-cycle strobe: take snapshot, arm, clear status |
| sample_tick_i | input | 1 | Single-cycle slow sample enable for the filter |
| wake_en_i | input | N_PINS | Per-pin wake enable |
| gpio_wake_sel_i | input | 1 | Global pin-wake select |
| filt_en_i | input | 1 | Digital filter enable for the pin wake source |
| analog_i | input | N_PINS | Per-pin analog mode (digital input forced to 1) |
| clear_i | input | 1 | Software clear of status and request; disarms |
| wake_req_o | output | 1 | Wake request to power control |
| gpio_wake_sts_o | output | 1 | Sticky flag: pin activity caused the wake |

## Verification
A wrong snapshot or a missing analog override shows up within three clock edges of the sleep strobe: the status rises with no pin activity, or stays low after a real change. A filter history that survives a sleep entry shows as a wake one or two ticks early. A miscounted history shows as a wake after the second tick instead of the third. A broken sticky path is visible on the cycle after the offending pin returns to its snapshot level.

// File: rtl/wcm_pkg.sv
package wcm_pkg;
  parameter int unsigned FILT_LEN = 3;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/wcm_sync.sv
module wcm_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = wcm_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wcm_filter.sv
module wcm_filter #(
  parameter int unsigned W   = 16,
  parameter int unsigned LEN = wcm_pkg::FILT_LEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] din_i,
  input  logic [W-1:0] snap_i,
  output logic         full_o,
  output logic [W-1:0] chg_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(LEN);

  logic [CW-1:0] cnt_q;

  // samples taken since last sleep entry, saturating at LEN
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == CNT_FULL);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [LEN-1:0] hist_q;
    logic           agree;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        hist_q <= '0;
      else if (restart_i) hist_q <= '0;
      else if (tick_i)    hist_q <= {hist_q[LEN-2:0], din_i[i]};
    end

    assign agree    = (&hist_q) | ~(|hist_q);
    assign chg_o[i] = full_o & agree & (hist_q[0] != snap_i[i]);
  end
endmodule

// File: rtl/wake_change_monitor.sv
module wake_change_monitor #(
  parameter int unsigned N_PINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pins_i,
  input  logic              sleep_enter_i,
  input  logic              sample_tick_i,
  input  logic [N_PINS-1:0] wake_en_i,
  input  logic              gpio_wake_sel_i,
  input  logic              filt_en_i,
  input  logic [N_PINS-1:0] analog_i,
  input  logic              clear_i,
  output logic              wake_req_o,
  output logic              gpio_wake_sts_o
);
  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] din;
  logic [N_PINS-1:0] snap_q;
  logic [N_PINS-1:0] raw_chg;
  logic [N_PINS-1:0] filt_chg;
  logic [N_PINS-1:0] sel_chg;
  logic              filt_full;
  logic              armed_q;
  logic              sts_q;
  logic              hit;

  wcm_sync #(.W(N_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pin_sync)
  );

  // analog pins read as 1 at the digital input
  assign din = pin_sync | analog_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            snap_q <= '0;
    else if (sleep_enter_i) snap_q <= din;
  end

  wcm_filter #(.W(N_PINS)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (sleep_enter_i),
    .tick_i    (sample_tick_i),
    .din_i     (din),
    .snap_i    (snap_q),
    .full_o    (filt_full),
    .chg_o     (filt_chg)
  );

  assign raw_chg = din ^ snap_q;
  assign sel_chg = filt_en_i ? filt_chg : raw_chg;
  assign hit     = armed_q & gpio_wake_sel_i & (|(sel_chg & wake_en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            armed_q <= 1'b0;
    else if (sleep_enter_i) armed_q <= 1'b1;
    else if (clear_i)       armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       sts_q <= 1'b0;
    else if (sleep_enter_i || clear_i) sts_q <= 1'b0;
    else if (hit)                      sts_q <= 1'b1;
  end

  assign wake_req_o      = sts_q;
  assign gpio_wake_sts_o = sts_q;
endmodule

// File: rtl/wcm_checker.sv
module wcm_checker #(
  parameter int unsigned N_PINS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_enter_i,
  input logic              clear_i,
  input logic              gpio_wake_sel_i,
  input logic              filt_en_i,
  input logic [N_PINS-1:0] wake_en_i,
  input logic              sts_i,
  input logic              armed_i,
  input logic              filt_full_i
);
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_i && !clear_i && !sleep_enter_i |=> sts_i); // R9
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !sts_i); // R9
  AST_SLEEP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_enter_i |=> !sts_i); // R9
  AST_GSEL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpio_wake_sel_i && !sts_i |=> !sts_i); // R4
  AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|wake_en_i) && !sts_i |=> !sts_i); // R3
  AST_WAKE_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_i) |-> $past(armed_i)); // R11
  AST_FILT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_i) && $past(filt_en_i) |-> $past(filt_full_i)); // R7
endmodule

bind wake_change_monitor wcm_checker #(.N_PINS(N_PINS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sleep_enter_i   (sleep_enter_i),
  .clear_i         (clear_i),
  .gpio_wake_sel_i (gpio_wake_sel_i),
  .filt_en_i       (filt_en_i),
  .wake_en_i       (wake_en_i),
  .sts_i           (sts_q),
  .armed_i         (armed_q),
  .filt_full_i     (filt_full)
);

// File: tb/tb_wake_change_monitor.sv
module tb_wake_change_monitor;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic         sleep_enter = 1'b0;
  logic         tick = 1'b0;
  logic [N-1:0] wake_en = '1;
  logic         gsel = 1'b1;
  logic         filt_en = 1'b0;
  logic [N-1:0] analog = '0;
  logic         clr = 1'b0;
  logic         wake_req, sts;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  wake_change_monitor #(.N_PINS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .sleep_enter_i(sleep_enter),
    .sample_tick_i(tick), .wake_en_i(wake_en), .gpio_wake_sel_i(gsel),
    .filt_en_i(filt_en), .analog_i(analog), .clear_i(clr),
    .wake_req_o(wake_req), .gpio_wake_sts_o(sts)
  );

  task automatic check(input string req, input logic exp);
    n_vec++;
    if (sts !== exp || wake_req !== exp) begin
      n_bad++;
      $display("FAIL %s: sts=%b req=%b expected %b", req, sts, wake_req, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_enter = 1'b1; @(negedge clk); sleep_enter = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0; cyc(1);
  endtask

  task automatic setup(input logic [N-1:0] p);
    pulse_clr();
    wake_en = '1; gsel = 1'b1; filt_en = 1'b0; analog = '0;
    pins = p; cyc(4);
    pulse_sleep();
  endtask

  task automatic t_reset();
    check("R10 reset", 1'b0);
    pins = 16'hffff; cyc(5);
    check("R10 unarmed change", 1'b0);
    pins = '0; cyc(4);
  endtask

  task automatic t_steady();
    setup(16'ha5c3); cyc(10);
    check("R1 steady pins", 1'b0);
  endtask

  task automatic t_rise();
    setup(16'h0000);
    pins[3] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R6 not before 3rd edge", 1'b0);
    @(posedge clk); @(negedge clk);
    check("R6 R2 rise wakes", 1'b1);
    pins[3] = 1'b0; cyc(5);
    check("R9 sticky after return", 1'b1);
    pulse_clr();
    check("R9 clear", 1'b0);
    pins[3] = 1'b1; cyc(5);
    check("R11 disarmed after clear", 1'b0);
  endtask

  task automatic t_fall();
    setup(16'h0020);
    pins[5] = 1'b0; cyc(4);
    check("R2 fall wakes", 1'b1);
    pulse_sleep();
    check("R9 sleep entry clears", 1'b0);
  endtask

  task automatic t_mask();
    setup(16'h0000);
    wake_en = 16'hff7f;
    pins[7] = 1'b1; cyc(5);
    check("R3 masked pin", 1'b0);
    pins[8] = 1'b1; cyc(4);
    check("R3 enabled pin", 1'b1);
  endtask

  task automatic t_gsel();
    setup(16'h0000);
    gsel = 1'b0;
    pins[1] = 1'b1; cyc(5);
    check("R4 global select off", 1'b0);
  endtask

  task automatic t_analog();
    pulse_clr();
    wake_en = '1; gsel = 1'b1; filt_en = 1'b0; analog = 16'h0004;
    pins = '0; cyc(4); pulse_sleep();
    pins[2] = 1'b1; cyc(4); pins[2] = 1'b0; cyc(4); pins[2] = 1'b1; cyc(4);
    check("R5 analog pin", 1'b0);
  endtask

  task automatic t_filter();
    setup(16'h0000);
    filt_en = 1'b1;
    pins[1] = 1'b1; cyc(4);
    pulse_tick(); pulse_tick();
    check("R7 two samples", 1'b0);
    pulse_tick();
    check("R7 three samples", 1'b1);
  endtask

  task automatic t_glitch();
    setup(16'h0000);
    filt_en = 1'b1;
    pins[1] = 1'b1; cyc(4);
    pulse_tick(); pulse_tick();
    pins[1] = 1'b0; cyc(4);
    pulse_tick(); pulse_tick(); pulse_tick(); pulse_tick();
    check("R8 short deviation", 1'b0);
  endtask

  task automatic t_hist_reset();
    setup(16'h0000);
    filt_en = 1'b1;
    pins[4] = 1'b1; cyc(4);
    pulse_tick(); pulse_tick();
    pins[4] = 1'b0; cyc(4);
    pulse_sleep();
    pins[4] = 1'b1; cyc(4);
    pulse_tick();
    check("R9 history reset on sleep", 1'b0);
    pulse_tick();
    check("R7 second sample after reset", 1'b0);
    pulse_tick();
    check("R7 third sample after reset", 1'b1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_steady();
    t_rise();
    t_fall();
    t_mask();
    t_gsel();
    t_analog();
    t_filter();
    t_glitch();
    t_hist_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule